// File: doc/BRIEF.md
# Masked-Compare Periodic Interrupt Timer

This block is a free-running 48-bit up-counter with a 48-bit compare value and a 48-bit per-bit mask. Each cycle the counter is compared against the compare value. Any bit position whose mask bit is 1 counts as equal no matter what it holds. Masking the upper bits therefore turns one compare value into a match that repeats every power-of-two count.

A match sets a sticky flag, and the interrupt output follows that flag as a level. Software clears the flag by writing 1 to it. Two options apply to the counter: it can be cleared to zero on the edge after a match, and it can stop while a debug-halt input is high.

Software reaches everything through a simple 32-bit register port with a registered read path. Each 48-bit quantity appears as a 32-bit low word and a 16-bit high word.

Top module: `mct_timer`

## Requirements
- R1: After reset the compare low word reads 0xFFFFFFFF, the compare high word 0x0000FFFF, both mask words and both counter words 0, and the control register 0xC.
- R2: Register byte offsets are: compare low 0x00, mask low 0x04, control 0x08, counter low 0x0C, compare high 0x10, mask high 0x14, counter high 0x1C. Offset 0x18 and any unaligned address read 0 and ignore writes. High words keep only bits 15:0; bits 31:16 read 0. `rdata` shows the register addressed at the previous rising edge.
- R3: While control bit 3 (run) is 1 and the counter is not halted, the counter rises by one per clock and wraps from all ones to zero. The carry crosses from the low word into the high word.
- R4: While control bit 3 is 0, the counter holds its value.
- R5: While control bit 2 is 1 and `dbg_halt` is 1, the counter holds. While control bit 2 is 0, `dbg_halt` has no effect.
- R6: A software write to either counter word replaces that word on the next edge. It takes priority over counting and clearing and leaves the other word unchanged.
- R7: Control bit 0 (flag) becomes 1 on the edge after any cycle in which every unmasked counter bit equals the compare bit. A mask bit of 1 forces its position to count as equal.
- R8: Writing control with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it unchanged. Otherwise the flag is sticky.
- R9: If a match and a clearing write fall in the same cycle, the flag stays 1.
- R10: With control bit 1 = 1, the counter is 0 on the edge after a matching cycle.
- R11: `irq` is high exactly when the flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | AW (5) | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Registered read data for the previous cycle's address |
| dbg_halt | input | 1 | Debug halt request |
| irq | output | 1 | Level interrupt, equal to the flag |

## Verification
The bench uses the default 48-bit counter over a 32-bit data port, so every 48-bit quantity is split unevenly into a 32-bit and a 16-bit word. Because the counter can be loaded through its two words, states such as all ones and the low-to-high carry can be reached in a few cycles rather than 2^48. Random counter, compare and mask triples are biased so that about half of them match only through the mask. Matches can also be held on a stopped counter, which lets the bench line up a hardware set against a software clear in the same cycle.

// File: rtl/mct_pkg.sv
package mct_pkg;

  typedef enum logic [2:0] {
    IDX_CMP_LO = 3'd0,
    IDX_MSK_LO = 3'd1,
    IDX_CTRL   = 3'd2,
    IDX_CNT_LO = 3'd3,
    IDX_CMP_HI = 3'd4,
    IDX_MSK_HI = 3'd5,
    IDX_RSVD   = 3'd6,
    IDX_CNT_HI = 3'd7
  } reg_idx_e;

  // control register bit positions
  localparam int CTL_FLAG    = 0;
  localparam int CTL_AUTOCLR = 1;
  localparam int CTL_DBGSTOP = 2;
  localparam int CTL_RUN     = 3;
  localparam int CTL_BITS    = 4;

  localparam logic [CTL_BITS-1:0] CTL_RESET = 4'hC;

endpackage

// File: rtl/mct_split_reg.sv
// Wide register loaded one bus word at a time (low word, then upper bits).
module mct_split_reg #(
  parameter int          W   = 48,
  parameter int          DW  = 32,
  parameter logic [W-1:0] RST = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [W-1:0]  q
);
  localparam int HI_W = W - DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST;
    end else begin
      if (wr_lo) q[DW-1:0] <= wdata;
      if (wr_hi) q[W-1:DW] <= wdata[HI_W-1:0];
    end
  end
endmodule

// File: rtl/mct_counter.sv
// Free-running counter: software load > clear-on-match > step.
module mct_counter #(
  parameter int W  = 48,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [DW-1:0] wdata,
  input  logic          clr,
  input  logic          step,
  output logic [W-1:0]  cnt
);
  localparam int HI_W = W - DW;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (ld_lo || ld_hi) begin
      if (ld_lo) cnt[DW-1:0] <= wdata;
      if (ld_hi) cnt[W-1:DW] <= wdata[HI_W-1:0];
    end else if (clr) begin
      cnt <= '0;
    end else if (step) begin
      cnt <= cnt + W'(1);
    end
  end
endmodule

// File: rtl/mct_match.sv
// Per-bit masked equality; a set mask bit forces that position equal.
module mct_match #(
  parameter int W = 48
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp,
  input  logic [W-1:0] msk,
  output logic         hit
);
  logic [W-1:0] bit_eq;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_eq[i] = msk[i] | ~(cnt[i] ^ cmp[i]);
  end

  assign hit = &bit_eq;
endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int DW    = 32,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          dbg_halt,
  output logic          irq
);
  localparam int HI_W = CNT_W - DW;
  localparam logic [CNT_W-1:0] CMP_RST = '1;

  // ---------------- address decode ----------------
  reg_idx_e idx;
  logic     sel_ok;
  assign idx    = reg_idx_e'(bus_addr[4:2]);
  assign sel_ok = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 5) == '0);

  logic wr_ok;
  assign wr_ok = bus_wr && sel_ok;

  logic wr_cmp_lo, wr_cmp_hi, wr_msk_lo, wr_msk_hi, wr_ctl, wr_cnt_lo, wr_cnt_hi;
  assign wr_cmp_lo = wr_ok && (idx == IDX_CMP_LO);
  assign wr_cmp_hi = wr_ok && (idx == IDX_CMP_HI);
  assign wr_msk_lo = wr_ok && (idx == IDX_MSK_LO);
  assign wr_msk_hi = wr_ok && (idx == IDX_MSK_HI);
  assign wr_ctl    = wr_ok && (idx == IDX_CTRL);
  assign wr_cnt_lo = wr_ok && (idx == IDX_CNT_LO);
  assign wr_cnt_hi = wr_ok && (idx == IDX_CNT_HI);

  logic cnt_wr_any;
  assign cnt_wr_any = wr_cnt_lo || wr_cnt_hi;

  // ---------------- compare and mask storage ----------------
  logic [CNT_W-1:0] cmp_q, msk_q, cnt_q;

  mct_split_reg #(.W(CNT_W), .DW(DW), .RST(CMP_RST)) u_cmp (
    .clk(clk), .rst(rst), .wr_lo(wr_cmp_lo), .wr_hi(wr_cmp_hi),
    .wdata(bus_wdata), .q(cmp_q)
  );

  mct_split_reg #(.W(CNT_W), .DW(DW), .RST('0)) u_msk (
    .clk(clk), .rst(rst), .wr_lo(wr_msk_lo), .wr_hi(wr_msk_hi),
    .wdata(bus_wdata), .q(msk_q)
  );

  // ---------------- control ----------------
  logic ctl_run, ctl_stop, ctl_clr, flag_q;
  logic flag_clr_req;
  assign flag_clr_req = wr_ctl && bus_wdata[CTL_FLAG];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_run  <= CTL_RESET[CTL_RUN];
      ctl_stop <= CTL_RESET[CTL_DBGSTOP];
      ctl_clr  <= CTL_RESET[CTL_AUTOCLR];
    end else if (wr_ctl) begin
      ctl_run  <= bus_wdata[CTL_RUN];
      ctl_stop <= bus_wdata[CTL_DBGSTOP];
      ctl_clr  <= bus_wdata[CTL_AUTOCLR];
    end
  end

  // ---------------- match and counter ----------------
  logic hit;
  mct_match #(.W(CNT_W)) u_match (
    .cnt(cnt_q), .cmp(cmp_q), .msk(msk_q), .hit(hit)
  );

  logic step;
  assign step = ctl_run && !(ctl_stop && dbg_halt);

  mct_counter #(.W(CNT_W), .DW(DW)) u_cnt (
    .clk(clk), .rst(rst), .ld_lo(wr_cnt_lo), .ld_hi(wr_cnt_hi),
    .wdata(bus_wdata), .clr(hit && ctl_clr), .step(step), .cnt(cnt_q)
  );

  // hardware set has priority over software clear
  always_ff @(posedge clk) begin
    if (rst)               flag_q <= 1'b0;
    else if (hit)          flag_q <= 1'b1;
    else if (flag_clr_req) flag_q <= 1'b0;
  end

  assign irq = flag_q;

  // ---------------- registered read path ----------------
  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (sel_ok) begin
      case (idx)
        IDX_CMP_LO: rd_mux = cmp_q[DW-1:0];
        IDX_CMP_HI: rd_mux = DW'(cmp_q[CNT_W-1:DW]);
        IDX_MSK_LO: rd_mux = msk_q[DW-1:0];
        IDX_MSK_HI: rd_mux = DW'(msk_q[CNT_W-1:DW]);
        IDX_CNT_LO: rd_mux = cnt_q[DW-1:0];
        IDX_CNT_HI: rd_mux = DW'(cnt_q[CNT_W-1:DW]);
        IDX_CTRL:   rd_mux = DW'({ctl_run, ctl_stop, ctl_clr, flag_q});
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/mct_timer_chk.sv
module mct_timer_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] cnt,
  input logic             hit,
  input logic             run_en,
  input logic             stop_en,
  input logic             clr_en,
  input logic             dbg_halt,
  input logic             cnt_wr,
  input logic             flag_clr,
  input logic             irq
);
  p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
    hit |=> irq);

  p_w1c_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !hit) |=> !irq);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (!hit && !flag_clr) |=> $stable(irq));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (hit && flag_clr) |=> irq);

  p_count_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run_en && !(stop_en && dbg_halt) && !cnt_wr && !(hit && clr_en))
      |=> cnt == $past(cnt) + CNT_W'(1));

  p_count_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !cnt_wr && !(hit && clr_en)) |=> $stable(cnt));

  p_debug_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (stop_en && dbg_halt && !cnt_wr && !(hit && clr_en)) |=> $stable(cnt));

  p_clear_on_hit_r10: assert property (@(posedge clk) disable iff (rst)
    (hit && clr_en && !cnt_wr) |=> cnt == '0);
endmodule

bind mct_timer mct_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .cnt(cnt_q), .hit(hit), .run_en(ctl_run),
  .stop_en(ctl_stop), .clr_en(ctl_clr), .dbg_halt(dbg_halt),
  .cnt_wr(cnt_wr_any), .flag_clr(flag_clr_req), .irq(irq)
);

// File: tb/mct_timer_tb.sv
module mct_timer_tb;
  localparam logic [4:0] A_CMP_LO = 5'h00, A_MSK_LO = 5'h04, A_CTL = 5'h08,
                         A_CNT_LO = 5'h0C, A_CMP_HI = 5'h10, A_MSK_HI = 5'h14,
                         A_RSVD = 5'h18, A_CNT_HI = 5'h1C;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  addr;
  logic        wr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        dbg_halt;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  mct_timer u_dut (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_wdata(wdata),
    .bus_rdata(rdata), .dbg_halt(dbg_halt), .irq(irq)
  );

  function automatic bit hit_f(input logic [47:0] c, input logic [47:0] p,
                               input logic [47:0] m);
    return (((c ^ p) & ~m) == 48'h0);
  endfunction

  task automatic check(input string tag, input logic [47:0] act, input logic [47:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(posedge clk); #1;
    wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; wr = 1'b0;
    @(posedge clk); #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr48(input logic [4:0] alo, input logic [4:0] ahi, input logic [47:0] v);
    wr_reg(alo, v[31:0]);
    wr_reg(ahi, {16'h0, v[47:32]});
  endtask

  task automatic rd_cnt(output logic [47:0] v);
    logic [31:0] lo, hi;
    rd_reg(A_CNT_LO, lo);
    rd_reg(A_CNT_HI, hi);
    v = {hi[15:0], lo};
  endtask

  // stopped timer, loads mask, compare, counter; then clears the flag
  task automatic set_state(input logic [47:0] c, input logic [47:0] p, input logic [47:0] m);
    wr_reg(A_CTL, 32'h0);
    wr48(A_MSK_LO, A_MSK_HI, m);
    wr48(A_CMP_LO, A_CMP_HI, p);
    wr48(A_CNT_LO, A_CNT_HI, c);
    wr_reg(A_CTL, 32'h1);
    idle(1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [47:0] v, c, p, m;
    void'($urandom(32'd1234));
    rst = 1'b1; wr = 1'b0; addr = A_CNT_LO; wdata = '0; dbg_halt = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    check("R1 counter low at reset", rdata, 0);
    rd_reg(A_CTL, d);       check("R1 control reset", d, 32'hC);
    check("R11 irq low after reset", irq, 0);
    wr_reg(A_CTL, 32'h0);
    rd_reg(A_CMP_LO, d);    check("R1 compare low reset", d, 32'hFFFF_FFFF);
    rd_reg(A_CMP_HI, d);    check("R1 compare high reset", d, 32'h0000_FFFF);
    rd_reg(A_MSK_LO, d);    check("R1 mask low reset", d, 0);
    rd_reg(A_MSK_HI, d);    check("R1 mask high reset", d, 0);
    rd_reg(A_CNT_HI, d);    check("R1 counter high reset", d, 0);

    // R2 register map and high-word width
    wr_reg(A_CMP_LO, 32'hDEAD_BEEF);
    wr_reg(A_CMP_HI, 32'hABCD_1234);
    wr_reg(A_MSK_HI, 32'h5555_8001);
    wr_reg(A_RSVD, 32'hFFFF_FFFF);
    wr_reg(5'h01, 32'h0);   // unaligned: ignored
    rd_reg(A_CMP_LO, d);    check("R2 compare low readback", d, 32'hDEAD_BEEF);
    rd_reg(A_CMP_HI, d);    check("R2 compare high 16 bits", d, 32'h0000_1234);
    rd_reg(A_MSK_HI, d);    check("R2 mask high 16 bits", d, 32'h0000_8001);
    rd_reg(A_RSVD, d);      check("R2 reserved reads zero", d, 0);
    rd_reg(5'h09, d);       check("R2 unaligned reads zero", d, 0);
    rd_reg(A_CTL, d);       check("R2 control readback", d, 0);

    // R3 counting
    set_state(48'd1000, 48'hFFFF_FFFF_FFFF, 48'h0);
    wr_reg(A_CTL, 32'h8); idle(6); wr_reg(A_CTL, 32'h0);
    rd_cnt(v); check("R3 count by one per clock", v, 48'd1007);
    // R4 hold while disabled
    idle(5);
    rd_cnt(v); check("R4 disabled counter holds", v, 48'd1007);
    // R3 wrap and carry
    set_state(48'hFFFF_FFFF_FFFE, 48'h123, 48'h0);
    wr_reg(A_CTL, 32'h8); idle(2); wr_reg(A_CTL, 32'h0);
    rd_cnt(v); check("R3 wrap to zero", v, 48'd1);
    set_state(48'h0000_FFFF_FFFF, 48'h123, 48'h0);
    wr_reg(A_CTL, 32'h8); wr_reg(A_CTL, 32'h0);
    rd_cnt(v); check("R3 carry into high word", v, 48'h0001_0000_0000);

    // R5 debug halt
    set_state(48'd100, 48'h123, 48'h0);
    @(negedge clk) dbg_halt = 1'b1;
    wr_reg(A_CTL, 32'hC); idle(5); wr_reg(A_CTL, 32'h0);
    rd_cnt(v); check("R5 halted while dbg_halt", v, 48'd100);
    wr_reg(A_CTL, 32'h8); idle(2); wr_reg(A_CTL, 32'h0);
    rd_cnt(v); check("R5 dbg_halt ignored when stop bit 0", v, 48'd103);
    @(negedge clk) dbg_halt = 1'b0;

    // R6 software write wins over counting
    set_state(48'h0007_0000_0010, 48'h123, 48'h0);
    wr_reg(A_CTL, 32'h8); wr_reg(A_CNT_LO, 32'h55); wr_reg(A_CTL, 32'h0);
    rd_cnt(v); check("R6 counter low write during run", v, 48'h0007_0000_0056);

    // R7 / R11 match and mask
    c = 48'h1234_5678_9ABC;
    set_state(c, c ^ 48'hF0, 48'hF0);
    check("R7 masked bits compare equal", irq, 1);
    rd_reg(A_CTL, d); check("R7 flag in control bit 0", d, 32'h1);
    set_state(c, c ^ 48'hF0, 48'h70);
    check("R7 unmasked difference no match", irq, 0);
    set_state(c, c, 48'h0);
    check("R11 irq follows flag", irq, 1);

    // R8 sticky, write-0 no effect, write-1 clears
    wr_reg(A_CNT_LO, 32'h0); idle(1);
    check("R8 flag sticky after match ends", irq, 1);
    wr_reg(A_CTL, 32'h0); idle(1);
    check("R8 write 0 leaves flag", irq, 1);
    wr_reg(A_CTL, 32'h1); idle(1);
    check("R8 write 1 clears flag", irq, 0);

    // R9 set wins (set_state clears while match is held)
    set_state(48'h42, 48'h42, 48'h0);
    wr_reg(A_CTL, 32'h1);
    check("R9 set wins over clear", irq, 1);

    // R10 clear on match
    set_state(48'd5, 48'd7, 48'h0);
    wr_reg(A_CTL, 32'hA); idle(3); wr_reg(A_CTL, 32'h0);
    rd_cnt(v); check("R10 counter cleared after match", v, 48'd1);
    check("R7 flag set by running match", irq, 1);
    set_state(48'd5, 48'd7, 48'h0);
    wr_reg(A_CTL, 32'h8); idle(3); wr_reg(A_CTL, 32'h0);
    rd_cnt(v); check("R10 no clear when bit 1 is 0", v, 48'd9);

    // R7 periodic match through mask (low 3 bits compared)
    set_state(48'd0, 48'd3, ~48'h7);
    wr_reg(A_CTL, 32'h8); idle(1);
    wr_reg(A_CTL, 32'h0);
    check("R7 periodic match not yet", irq, 0);
    wr_reg(A_CNT_LO, 32'd11); idle(1);
    check("R7 periodic match at 11", irq, 1);

    // random masked compares
    for (int i = 0; i < 40; i++) begin
      c = {$urandom(), $urandom()};
      m = {$urandom(), $urandom()} & {$urandom(), $urandom()};
      p = (i % 2 == 0) ? (c ^ ({$urandom(), $urandom()} & m)) : {$urandom(), $urandom()};
      set_state(c, p, m);
      check("R7 random masked compare", irq, hit_f(c, p, m));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule